// File: doc/BRIEF.md
# Software-Filled Set-Associative Address Translation Buffer

This block keeps a small set-associative table of virtual-to-physical page translations that software fills and inspects itself. Three configuration registers are reachable through a simple write port: a page register holding a virtual page number, a control register holding the current process ID, a way pointer, a commit-enable bit and a read trigger, and an attribute register holding the per-page flags and the physical frame number. All three registers are always visible on read-back outputs.

When commit-enable is set, a write to the attribute register stores a new entry. The entry is built from the attribute value, the page register and the process ID. Its slot is chosen by the low bits of the page number (the line) and by the way pointer. The way pointer then advances, so that a run of writes fills successive ways. A control-register write with the read trigger set copies a stored entry back into the attribute register.

A separate lookup port translates one address per cycle. It returns, one cycle later, a hit or miss indication, the frame number, the cacheable flag and a permission fault for the requested kind of access.

Top module: `xlt_buf_top`

## Requirements
- R1: After reset, all three configuration registers read zero and every stored entry is invalid, so every lookup misses.
- R2: Configuration writes use register code 0 for the page register (page number in bits VPN_W-1:0), code 1 for the control register and code 2 for the attribute register. An attribute write always updates that register. Its bits 31:25 are never kept and always read as zero. Bit 24 is cacheable, bit 23 load-allowed, bit 22 store-allowed, bit 21 execute-allowed, bit 20 global, and bits 19:0 hold the frame number.
- R3: The control register keeps the process ID in bits PID_W-1:0, commit-enable in bit 18 and the way pointer in bits 21:20. With commit-enable at 1, an attribute write stores a valid entry at line = page number bits 3:0, way = way pointer, tagged with the upper page-number bits and the process ID. With commit-enable at 0, nothing is stored.
- R4: Every commit advances the way pointer by one, wrapping from way WAYS-1 to way 0.
- R5: A control-register write with bit 19 set loads the attribute register from the entry at the page register's line and the way field of that same write. Bit 19 always reads back as zero.
- R6: A lookup matches an entry only when the entry is valid and its tag equals the upper page-number bits. The process IDs must also be equal, unless the entry's global flag is 1.
- R7: Access type 0 (load) needs the load-allowed flag, 1 (store) needs the store-allowed flag, and 2 (fetch) needs the execute-allowed flag. Type 3 always faults on a hit. A hit that lacks the needed flag raises the fault output. A hit returns the entry's frame number and cacheable flag.
- R8: Lookup results appear on the cycle after the request, flagged by a result-valid strobe. Hit and miss are exclusive, and a miss never raises a fault.
- R9: When several ways of a line match, the lowest-numbered way supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register code: 0 page, 1 control, 2 attribute |
| cfg_wdata | input | 32 | Configuration write data |
| page_rd | output | 32 | Page register read-back |
| ctrl_rd | output | 32 | Control register read-back |
| attr_rd | output | 32 | Attribute register read-back |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_pid | input | PID_W | Lookup process ID |
| lk_kind | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| lk_rvalid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No valid matching entry |
| lk_pfn | output | PFN_W | Translated frame number |
| lk_cache | output | 1 | Access is cacheable |
| lk_fault | output | 1 | Permission fault on a hit |

## Verification
The bench builds the block with its default parameters: four ways, sixteen lines, a 20-bit page number and an 8-bit process ID. With four ways, the way pointer wraps after only four commits. It is then driven past the wrap into a line that already holds two entries for the same page, which tests both the wrap and the lowest-way priority. Sixteen lines let tags that differ only above bit 3 share one line. This keeps global-flag and process-ID matching separate from line selection.

// File: rtl/xlt_buf_pkg.sv
package xlt_buf_pkg;

  typedef enum logic [1:0] {
    REG_PAGE = 2'd0,
    REG_CTRL = 2'd1,
    REG_ATTR = 2'd2
  } cfg_reg_e;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2
  } acc_kind_e;

  // attribute register bit positions
  localparam int ATTR_IG_LSB = 25;
  localparam int ATTR_FLAG_LSB = 20;
  localparam int FLAG_W = 5;
  // flag order inside the 5-bit flag group (LSB first)
  localparam int FL_G = 0;
  localparam int FL_X = 1;
  localparam int FL_W = 2;
  localparam int FL_R = 3;
  localparam int FL_C = 4;

  // control register bit positions
  localparam int CTRL_WE = 18;
  localparam int CTRL_RD = 19;
  localparam int CTRL_WAY_LSB = 20;

endpackage

// File: rtl/xlt_cfg_regs.sv
module xlt_cfg_regs
  import xlt_buf_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PID_W  = 8,
  parameter int PFN_W  = 20,
  parameter int LINE_W = 4,
  parameter int WAYS   = 4,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W  = VPN_W - LINE_W,
  localparam int ATTR_W = FLAG_W + PFN_W,
  localparam int ENT_W  = TAG_W + PID_W + ATTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       page_q,
  output logic [31:0]       ctrl_q,
  output logic [31:0]       attr_q,
  output logic              commit_o,
  output logic [LINE_W-1:0] wr_line_o,
  output logic [WAY_W-1:0]  wr_way_o,
  output logic [ENT_W-1:0]  wr_entry_o,
  output logic              rd_fire_o,
  output logic [LINE_W-1:0] rd_line_o,
  output logic [WAY_W-1:0]  rd_way_o,
  input  logic [ATTR_W-1:0] rd_attr_i
);

  localparam logic [WAY_W-1:0] WAY_LAST = WAY_W'(WAYS - 1);

  logic [VPN_W-1:0]  vpn_r;
  logic [PID_W-1:0]  pid_r;
  logic [WAY_W-1:0]  way_r;
  logic              we_r;
  logic [ATTR_W-1:0] attr_r;

  logic wr_page, wr_ctrl, wr_attr;

  assign wr_page = cfg_we && (cfg_addr == REG_PAGE);
  assign wr_ctrl = cfg_we && (cfg_addr == REG_CTRL);
  assign wr_attr = cfg_we && (cfg_addr == REG_ATTR);

  assign commit_o   = wr_attr && we_r;
  assign wr_line_o  = vpn_r[LINE_W-1:0];
  assign wr_way_o   = way_r;
  assign wr_entry_o = {vpn_r[VPN_W-1:LINE_W], pid_r, cfg_wdata[ATTR_W-1:0]};

  assign rd_fire_o = wr_ctrl && cfg_wdata[CTRL_RD];
  assign rd_line_o = vpn_r[LINE_W-1:0];
  assign rd_way_o  = cfg_wdata[CTRL_WAY_LSB +: WAY_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      vpn_r  <= '0;
      pid_r  <= '0;
      way_r  <= '0;
      we_r   <= 1'b0;
      attr_r <= '0;
    end else begin
      if (wr_page) vpn_r <= cfg_wdata[VPN_W-1:0];
      if (wr_ctrl) begin
        pid_r <= cfg_wdata[PID_W-1:0];
        we_r  <= cfg_wdata[CTRL_WE];
        way_r <= cfg_wdata[CTRL_WAY_LSB +: WAY_W];
      end else if (commit_o) begin
        way_r <= (way_r == WAY_LAST) ? '0 : way_r + 1'b1;
      end
      if (wr_attr) attr_r <= cfg_wdata[ATTR_W-1:0];
      else if (rd_fire_o) attr_r <= rd_attr_i;
    end
  end

  assign page_q = {{(32-VPN_W){1'b0}}, vpn_r};
  assign attr_q = {{(32-ATTR_W){1'b0}}, attr_r};

  always_comb begin
    ctrl_q = '0;
    ctrl_q[PID_W-1:0] = pid_r;
    ctrl_q[CTRL_WE] = we_r;
    ctrl_q[CTRL_WAY_LSB +: WAY_W] = way_r;
  end

  AST_WAY_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> (way_r == (($past(way_r) == WAY_LAST) ? '0 : $past(way_r) + 1'b1))); // R4

  AST_READ_LOADS_ATTR: assert property (@(posedge clk) disable iff (rst)
    rd_fire_o |=> (attr_q[ATTR_W-1:0] == $past(rd_attr_i))); // R5

  AST_ATTR_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    wr_attr |=> (attr_q[ATTR_W-1:0] == $past(cfg_wdata[ATTR_W-1:0]))); // R2

endmodule

// File: rtl/xlt_way_bank.sv
module xlt_way_bank #(
  parameter int TAG_W  = 16,
  parameter int PID_W  = 8,
  parameter int ATTR_W = 25,
  parameter int LINE_W = 4,
  parameter int GBIT   = 20,
  localparam int LINES = 1 << LINE_W,
  localparam int ENT_W = TAG_W + PID_W + ATTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [ENT_W-1:0]  wr_entry,
  input  logic [LINE_W-1:0] rd_line,
  output logic [ATTR_W-1:0] rd_attr,
  input  logic [LINE_W-1:0] lk_line,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [PID_W-1:0]  lk_pid,
  output logic              lk_match,
  output logic [ATTR_W-1:0] lk_attr
);

  // entry storage without reset so it maps onto distributed RAM
  logic [ENT_W-1:0] mem [LINES];
  logic [LINES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_line] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_line] <= 1'b1;
  end

  logic [ENT_W-1:0] lk_ent;
  logic [TAG_W-1:0] ent_tag;
  logic [PID_W-1:0] ent_pid;

  assign lk_ent  = mem[lk_line];
  assign ent_tag = lk_ent[ENT_W-1 -: TAG_W];
  assign ent_pid = lk_ent[ATTR_W +: PID_W];
  assign lk_attr = lk_ent[ATTR_W-1:0];
  assign lk_match = valid_q[lk_line] && (ent_tag == lk_tag) &&
                    (lk_ent[GBIT] || (ent_pid == lk_pid));

  logic [ENT_W-1:0] rd_ent;
  assign rd_ent  = mem[rd_line];
  assign rd_attr = rd_ent[ATTR_W-1:0];

  AST_COMMIT_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_line)]); // R3

  AST_RESET_EMPTY: assert property (@(posedge clk)
    $fell(rst) |-> (valid_q == '0)); // R1

endmodule

// File: rtl/xlt_resolve.sv
module xlt_resolve
  import xlt_buf_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int PFN_W = 20,
  localparam int ATTR_W = FLAG_W + PFN_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        lk_valid,
  input  logic [1:0]                  lk_kind,
  input  logic [WAYS-1:0]             match_i,
  input  logic [WAYS-1:0][ATTR_W-1:0] attr_i,
  output logic                        rvalid_o,
  output logic                        hit_o,
  output logic                        miss_o,
  output logic [PFN_W-1:0]            pfn_o,
  output logic                        cache_o,
  output logic                        fault_o
);

  logic              any_hit;
  logic [ATTR_W-1:0] sel_attr;
  logic [FLAG_W-1:0] fl;
  logic              allowed;

  // lowest way wins: scan from the top so the lowest match is last
  always_comb begin
    any_hit  = 1'b0;
    sel_attr = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_i[w]) begin
        any_hit  = 1'b1;
        sel_attr = attr_i[w];
      end
    end
  end

  assign fl = sel_attr[PFN_W +: FLAG_W];

  always_comb begin
    case (lk_kind)
      KIND_LOAD:  allowed = fl[FL_R];
      KIND_STORE: allowed = fl[FL_W];
      KIND_FETCH: allowed = fl[FL_X];
      default:    allowed = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_o <= 1'b0;
      hit_o    <= 1'b0;
      miss_o   <= 1'b0;
      pfn_o    <= '0;
      cache_o  <= 1'b0;
      fault_o  <= 1'b0;
    end else begin
      rvalid_o <= lk_valid;
      if (lk_valid) begin
        hit_o   <= any_hit;
        miss_o  <= !any_hit;
        pfn_o   <= any_hit ? sel_attr[PFN_W-1:0] : '0;
        cache_o <= any_hit && fl[FL_C];
        fault_o <= any_hit && !allowed;
      end
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rvalid_o); // R8

  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |-> (hit_o != miss_o)); // R8

  AST_MISS_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (rvalid_o && miss_o) |-> !fault_o); // R8

endmodule

// File: rtl/xlt_buf_top.sv
module xlt_buf_top
  import xlt_buf_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PID_W  = 8,
  parameter int PFN_W  = 20,
  parameter int LINES  = 16,
  parameter int WAYS   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      page_rd,
  output logic [31:0]      ctrl_rd,
  output logic [31:0]      attr_rd,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [1:0]       lk_kind,
  output logic             lk_rvalid,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_cache,
  output logic             lk_fault
);

  localparam int LINE_W = $clog2(LINES);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W  = VPN_W - LINE_W;
  localparam int ATTR_W = FLAG_W + PFN_W;
  localparam int ENT_W  = TAG_W + PID_W + ATTR_W;
  localparam int GBIT   = PFN_W + FL_G;

  logic              commit;
  logic [LINE_W-1:0] wr_line;
  logic [WAY_W-1:0]  wr_way;
  logic [ENT_W-1:0]  wr_entry;
  logic              rd_fire;
  logic [LINE_W-1:0] rd_line;
  logic [WAY_W-1:0]  rd_way;
  logic [ATTR_W-1:0] rd_attr_sel;

  logic [WAYS-1:0]             way_match;
  logic [WAYS-1:0][ATTR_W-1:0] way_lk_attr;
  logic [WAYS-1:0][ATTR_W-1:0] way_rd_attr;

  xlt_cfg_regs #(
    .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W), .LINE_W(LINE_W), .WAYS(WAYS)
  ) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .page_q(page_rd), .ctrl_q(ctrl_rd), .attr_q(attr_rd),
    .commit_o(commit), .wr_line_o(wr_line), .wr_way_o(wr_way), .wr_entry_o(wr_entry),
    .rd_fire_o(rd_fire), .rd_line_o(rd_line), .rd_way_o(rd_way),
    .rd_attr_i(rd_attr_sel)
  );

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    xlt_way_bank #(
      .TAG_W(TAG_W), .PID_W(PID_W), .ATTR_W(ATTR_W), .LINE_W(LINE_W), .GBIT(GBIT)
    ) u_bank (
      .clk(clk), .rst(rst),
      .wr_en(commit && (wr_way == WAY_W'(g))),
      .wr_line(wr_line), .wr_entry(wr_entry),
      .rd_line(rd_line), .rd_attr(way_rd_attr[g]),
      .lk_line(lk_vpn[LINE_W-1:0]), .lk_tag(lk_vpn[VPN_W-1:LINE_W]), .lk_pid(lk_pid),
      .lk_match(way_match[g]), .lk_attr(way_lk_attr[g])
    );
  end

  assign rd_attr_sel = way_rd_attr[rd_way];

  xlt_resolve #(.WAYS(WAYS), .PFN_W(PFN_W)) u_resolve (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_kind(lk_kind),
    .match_i(way_match), .attr_i(way_lk_attr),
    .rvalid_o(lk_rvalid), .hit_o(lk_hit), .miss_o(lk_miss),
    .pfn_o(lk_pfn), .cache_o(lk_cache), .fault_o(lk_fault)
  );

  AST_IG_NEVER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == REG_ATTR) |=> (attr_rd[31:ATTR_IG_LSB] == '0)); // R2

  AST_RD_BIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == REG_CTRL) |=> !ctrl_rd[CTRL_RD]); // R5

endmodule

// File: tb/test_xlt_buf_top.sv
`timescale 1ns/1ps
module test_xlt_buf_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] page_rd, ctrl_rd, attr_rd;
  logic        lk_valid = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [7:0]  lk_pid = '0;
  logic [1:0]  lk_kind = '0;
  logic        lk_rvalid, lk_hit, lk_miss, lk_cache, lk_fault;
  logic [19:0] lk_pfn;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  xlt_buf_top i_xlt_buf_top (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .page_rd(page_rd), .ctrl_rd(ctrl_rd), .attr_rd(attr_rd),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid), .lk_kind(lk_kind),
    .lk_rvalid(lk_rvalid), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_pfn(lk_pfn), .lk_cache(lk_cache), .lk_fault(lk_fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [19:0] v, input logic [7:0] p, input logic [1:0] k);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_pid = p; lk_kind = k;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  // {vpn, pid, kind, hit, fault, cache, pfn}
  localparam logic [52:0] VEC [10] = '{
    {20'h00012, 8'h05, 2'd0, 1'b1, 1'b0, 1'b1, 20'hABCDE},
    {20'h00012, 8'h05, 2'd1, 1'b1, 1'b1, 1'b1, 20'hABCDE},
    {20'h00012, 8'h06, 2'd0, 1'b0, 1'b0, 1'b0, 20'h00000},
    {20'h00022, 8'h77, 2'd2, 1'b1, 1'b0, 1'b0, 20'h00111},
    {20'h00022, 8'h05, 2'd0, 1'b1, 1'b1, 1'b0, 20'h00111},
    {20'h00032, 8'h05, 2'd1, 1'b1, 1'b0, 1'b0, 20'h22222},
    {20'h00032, 8'h05, 2'd2, 1'b1, 1'b1, 1'b0, 20'h22222},
    {20'h00042, 8'h05, 2'd2, 1'b1, 1'b0, 1'b1, 20'h33333},
    {20'h00052, 8'h05, 2'd0, 1'b0, 1'b0, 1'b0, 20'h00000},
    {20'h00003, 8'h05, 2'd0, 1'b0, 1'b0, 1'b0, 20'h00000}
  };

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 page", page_rd, 32'h0);
    chk("R1 ctrl", ctrl_rd, 32'h0);
    chk("R1 attr", attr_rd, 32'h0);
    look(20'h00012, 8'h00, 2'd0);
    chk("R1 empty miss", {30'b0, lk_miss, lk_hit}, 32'h2);

    // fill line 2 with four ways (R3, R4)
    wr(2'd1, 32'h0004_0005);
    wr(2'd0, 32'h0000_0012);
    wr(2'd2, 32'hFF8A_BCDE);
    chk("R2 ig dropped", attr_rd, 32'h018A_BCDE);
    chk("R4 way step", ctrl_rd, 32'h0014_0005);
    wr(2'd0, 32'h0000_0022);
    wr(2'd2, 32'h0030_0111);
    wr(2'd0, 32'h0000_0032);
    wr(2'd2, 32'h00C2_2222);
    wr(2'd0, 32'h0000_0042);
    wr(2'd2, 32'h01E3_3333);
    chk("R4 way wrap", ctrl_rd, 32'h0004_0005);

    // table walk (R6 R7 R8)
    for (int i = 0; i < 10; i++) begin
      look(VEC[i][52:33], VEC[i][32:25], VEC[i][24:23]);
      chk("R8 rvalid", {31'b0, lk_rvalid}, 32'h1);
      chk("R6 hit", {31'b0, lk_hit}, {31'b0, VEC[i][22]});
      chk("R8 miss", {31'b0, lk_miss}, {31'b0, !VEC[i][22]});
      chk("R7 fault", {31'b0, lk_fault}, {31'b0, VEC[i][21]});
      if (VEC[i][22]) begin
        chk("R7 pfn", {12'b0, lk_pfn}, {12'b0, VEC[i][19:0]});
        chk("R7 cache", {31'b0, lk_cache}, {31'b0, VEC[i][20]});
      end
    end
    @(negedge clk);
    chk("R8 rvalid drops", {31'b0, lk_rvalid}, 32'h0);

    // R3 commit disabled: nothing stored
    wr(2'd1, 32'h0010_0009);
    wr(2'd0, 32'h0000_0013);
    wr(2'd2, 32'h00F4_4444);
    chk("R2 attr written", attr_rd, 32'h00F4_4444);
    look(20'h00013, 8'h09, 2'd0);
    chk("R3 no commit miss", {30'b0, lk_miss, lk_hit}, 32'h2);
    chk("R4 no step", ctrl_rd, 32'h0010_0009);

    // R5 read trigger
    wr(2'd0, 32'h0000_0022);
    wr(2'd1, 32'h0018_0005);
    chk("R5 read way1", attr_rd, 32'h0030_0111);
    chk("R5 rd bit zero", ctrl_rd, 32'h0010_0005);
    wr(2'd0, 32'h0000_0012);
    wr(2'd1, 32'h0008_0005);
    chk("R5 read way0", attr_rd, 32'h018A_BCDE);

    // R9 duplicates in line 5, then R4 wrap overwrite into way 0
    wr(2'd1, 32'h0024_0005);
    wr(2'd0, 32'h0000_0015);
    wr(2'd2, 32'h0085_5555);
    wr(2'd2, 32'h0086_6666);
    look(20'h00015, 8'h05, 2'd0);
    chk("R9 lowest way", {12'b0, lk_pfn}, 32'h0005_5555);
    wr(2'd2, 32'h0087_7777);
    look(20'h00015, 8'h05, 2'd0);
    chk("R9 R4 wrapped way0 wins", {12'b0, lk_pfn}, 32'h0007_7777);
    chk("R7 no fault", {31'b0, lk_fault}, 32'h0);

    // R1 reset again clears entries and registers
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 attr cleared", attr_rd, 32'h0);
    look(20'h00015, 8'h05, 2'd0);
    chk("R1 entries cleared", {30'b0, lk_miss, lk_hit}, 32'h2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule